// File: doc/BRIEF.md
# Serial-Parallel Multiplier

This block multiplies an unsigned M-bit operand that arrives one bit per clock, least-significant bit first, by an unsigned N-bit operand presented as a parallel word. The product comes out on a single wire, also least-significant bit first, together with a flag that marks the M+N product bits.

The datapath is a chain of N cells, one for each bit of the parallel operand. Each cell gates the serial bit with its operand bit, adds the result to the running sum from the previous cell and to its own stored carry, and keeps the new carry for the next column. A parameter chooses between two forms:
- In the plain form, the sums ripple through all cells within one cycle.
- In the pipelined form, a register sits between neighbouring cells. This shortens the clock path to a single adder. In exchange the first product bit comes out N-1 cycles later, and the serial operand is fed to the cells through a longer delay line.

A run begins with a one-cycle start strobe. Start clears all carries and pipeline state and captures the parallel operand. The block then takes the M serial bits in the M cycles that follow. After that it feeds itself zeros until the top product bits have come out.

Top module: `spm_mult`

## Requirements
- R1: For unsigned operands X (M bits) and Y (N bits), the bits shown on z_out while z_valid is high are the M+N bits of X*Y, least-significant bit first.
- R2: Bit k of X (k = 0..M-1) is taken from x_in in the (k+1)-th cycle after the cycle in which start is high. x_in has no effect in the start cycle, when idle, or after the M-th bit.
- R3: Y is captured from y_in in the start cycle. Changes to y_in during the run do not alter the product.
- R4: If start is high in cycle 0, z_valid first rises in cycle D+2, where D = 0 in the plain form and D = N-1 in the pipelined form.
- R5: In an uninterrupted run, z_valid stays high for exactly M+N consecutive cycles and then drops.
- R6: z_out is 0 in every cycle in which z_valid is low.
- R7: Start aborts any run in progress. z_valid is low in the cycle after start, and the new run's product is unaffected by the earlier run.
- R8: The pipelined form (FORM = SPM_PIPED) produces the same product bits as the plain form, delayed by N-1 cycles.
- R9: After a synchronous active-low reset, z_valid and z_out are 0 and stay 0 until a start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle strobe that begins a run |
| y_in | input | N_BITS | Parallel operand, captured with start |
| x_in | input | 1 | Serial operand, least-significant bit first |
| z_out | output | 1 | Serial product bit |
| z_valid | output | 1 | High while z_out carries a product bit |

## Verification
The assertions assume that start is a single-cycle pulse. They also assume that a run which is not aborted is left alone for its full length, so that the valid run length can be checked whenever z_valid falls without a start just before. The stimulus follows this rule for every full run. Its one abort places the second start after a chosen number of serial bits and accounts for the few low-order bits the plain form has already emitted. The bench also holds x_in high and scrambles y_in outside the sampled windows, so a design that leaks those inputs into the product gives wrong bits.

// File: rtl/spm_pkg.sv
// Shared definitions for the serial-parallel multiplier.
// Assumes: nothing beyond IEEE 1800-2017.
package spm_pkg;

    // Selects the datapath form: rippled sums or registered sums between cells.
    typedef enum logic {
        SPM_PLAIN = 1'b0,
        SPM_PIPED = 1'b1
    } spm_form_e;

    // Cycles by which the first product bit lags the plain form.
    function automatic int spm_extra_delay(spm_form_e form, int n_bits);
        return (form == SPM_PIPED) ? (n_bits - 1) : 0;
    endfunction

    // Spacing in cycles between the serial-bit taps of adjacent cells.
    function automatic int spm_tap_step(spm_form_e form);
        return (form == SPM_PIPED) ? 2 : 1;
    endfunction

endpackage

// File: rtl/spm_ctrl.sv
// Run sequencer: counts cycles from start, gates the serial operand to
// zero outside its M-bit window and flags cycles whose column is a product bit.
// Assumes: start is a single-cycle pulse; a new start aborts the running count.
module spm_ctrl #(
    parameter int M_BITS = 8,
    parameter int N_BITS = 6,
    parameter int DELAY  = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic x_in,
    output logic x_bit,
    output logic col_ok
);
    localparam int LAST = DELAY + M_BITS + N_BITS;
    localparam int CW   = $clog2(LAST + 1) + 1;
    localparam logic [CW-1:0] ONE_C   = CW'(1);
    localparam logic [CW-1:0] XEND_C  = CW'(M_BITS);
    localparam logic [CW-1:0] COL0_C  = CW'(DELAY + 1);
    localparam logic [CW-1:0] LAST_C  = CW'(LAST);

    logic [CW-1:0] cnt;

    // Cycle counter: 1 in the first cycle after start, returns to 0 when done.
    always_ff @(posedge clk) begin
        if (!rst_n)                              cnt <= '0;
        else if (start)                          cnt <= ONE_C;
        else if (cnt == '0 || cnt == LAST_C)     cnt <= '0;
        else                                     cnt <= cnt + ONE_C;
    end

    // Serial operand window: only the M cycles after start pass x_in.
    always_comb x_bit = (cnt >= ONE_C && cnt <= XEND_C) ? x_in : 1'b0;

    // Product column window at the last cell.
    always_comb col_ok = (cnt >= COL0_C && cnt <= LAST_C);

endmodule

// File: rtl/spm_xline.sv
// Delay line for the serial operand; tap k carries the input delayed k cycles.
// Assumes: DEPTH >= 1; clr empties the line synchronously.
module spm_xline #(
    parameter int DEPTH = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           d,
    output logic [DEPTH:0] taps
);
    logic [DEPTH:0] stage;

    // Tap 0 is the undelayed input.
    always_comb stage[0] = d;

    genvar k;
    generate
        for (k = 1; k <= DEPTH; k++) begin : g_stage
            // One-cycle delay per stage, cleared on reset or start.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) stage[k] <= 1'b0;
                else               stage[k] <= stage[k-1];
            end
        end
    endgenerate

    always_comb taps = stage;

endmodule

// File: rtl/spm_cell.sv
// One bit slice of the multiplier: AND of serial bit and operand bit,
// full adder with the incoming sum, and a carry held for the next column.
// Assumes: columns reach this cell in ascending order, one per cycle.
module spm_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic x_bit,
    input  logic y_bit,
    input  logic s_in,
    output logic s_out
);
    logic pp;
    logic carry_q;
    logic carry_d;

    // Partial-product bit and full-adder sum/carry.
    always_comb begin
        pp      = x_bit & y_bit;
        s_out   = pp ^ s_in ^ carry_q;
        carry_d = (pp & s_in) | (pp & carry_q) | (s_in & carry_q);
    end

    // Carry register feeding the next column of this slice.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) carry_q <= 1'b0;
        else               carry_q <= carry_d;
    end

    // R1
    carry_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(x_bit & y_bit) && !s_in && !clr) |=> !carry_q);

endmodule

// File: rtl/spm_mult.sv
// Serial-parallel unsigned multiplier. The serial operand enters LSB first,
// the parallel operand is captured on start, and the product leaves LSB first.
// FORM picks rippled sums (N-1 adders per cycle) or registered sums (one adder).
// Assumes: N_BITS >= 2; start is a single-cycle pulse.
module spm_mult #(
    parameter int                M_BITS = 8,
    parameter int                N_BITS = 6,
    parameter spm_pkg::spm_form_e FORM  = spm_pkg::SPM_PLAIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [N_BITS-1:0] y_in,
    input  logic              x_in,
    output logic              z_out,
    output logic              z_valid
);
    localparam int DELAY = spm_pkg::spm_extra_delay(FORM, N_BITS);
    localparam int STEP  = spm_pkg::spm_tap_step(FORM);
    localparam int DEPTH = (N_BITS - 1) * STEP;
    localparam int VW    = $clog2(M_BITS + N_BITS + 1) + 1;
    localparam logic [VW-1:0] RUNLEN = VW'(M_BITS + N_BITS);

    logic [N_BITS-1:0] y_q;
    logic              x_bit;
    logic              col_ok;
    logic [DEPTH:0]    taps;
    logic [N_BITS-1:0] sum;
    logic [N_BITS-1:0] link;

    // Parallel operand register, loaded on start.
    always_ff @(posedge clk) begin
        if (!rst_n)     y_q <= '0;
        else if (start) y_q <= y_in;
    end

    spm_ctrl #(
        .M_BITS (M_BITS),
        .N_BITS (N_BITS),
        .DELAY  (DELAY)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .x_in   (x_in),
        .x_bit  (x_bit),
        .col_ok (col_ok)
    );

    spm_xline #(
        .DEPTH (DEPTH)
    ) u_xline (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .d     (x_bit),
        .taps  (taps)
    );

    // First cell sees no incoming sum.
    always_comb link[0] = 1'b0;

    genvar i;
    generate
        for (i = 0; i < N_BITS; i++) begin : g_cell
            spm_cell u_cell (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (start),
                .x_bit (taps[i*STEP]),
                .y_bit (y_q[i]),
                .s_in  (link[i]),
                .s_out (sum[i])
            );
        end
        for (i = 0; i < N_BITS - 1; i++) begin : g_link
            if (FORM == spm_pkg::SPM_PIPED) begin : g_reg
                // Sum register between cells, cutting the adder path.
                always_ff @(posedge clk) begin
                    if (!rst_n || start) link[i+1] <= 1'b0;
                    else                 link[i+1] <= sum[i];
                end
            end else begin : g_wire
                always_comb link[i+1] = sum[i];
            end
        end
    endgenerate

    // Output register: product bit and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            z_out   <= 1'b0;
            z_valid <= 1'b0;
        end else begin
            z_out   <= col_ok & sum[N_BITS-1];
            z_valid <= col_ok;
        end
    end

    // Length of the current valid run, for the checks below.
    logic [VW-1:0] vrun;
    always_ff @(posedge clk) begin
        if (!rst_n || start) vrun <= '0;
        else if (z_valid)    vrun <= vrun + VW'(1);
        else                 vrun <= '0;
    end

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !z_valid);

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !z_valid |-> !z_out);

    // R5
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(z_valid) && !$past(start)) |-> (vrun == RUNLEN));

    // R5
    run_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z_valid |-> (vrun < RUNLEN));

endmodule

// File: tb/sim_spm_mult.sv
// Scoreboard bench: the driver pushes expected product bits into a queue per
// instance; monitors pop and compare whenever z_valid is seen high.
module sim_spm_mult;
    localparam int M = 8;
    localparam int N = 6;
    localparam int W = M + N;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         x_in = 1'b0;
    logic [N-1:0] y_in = '0;
    logic         z0, v0, z1, v1;

    always #4 clk = ~clk;

    spm_mult #(.M_BITS(M), .N_BITS(N), .FORM(spm_pkg::SPM_PLAIN)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .y_in(y_in), .x_in(x_in),
        .z_out(z0), .z_valid(v0));

    spm_mult #(.M_BITS(M), .N_BITS(N), .FORM(spm_pkg::SPM_PIPED)) u1 (
        .clk(clk), .rst_n(rst_n), .start(start), .y_in(y_in), .x_in(x_in),
        .z_out(z1), .z_valid(v1));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int fails  = 0;
    bit q0[$];
    bit q1[$];
    int on0 = -1;
    int on1 = -1;
    bit pv0 = 1'b0;
    bit pv1 = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    // Monitor for the plain form.
    always @(negedge clk) begin
        if (rst_n) begin
            if (v0 && !pv0) chk(cyc == on0, "R4", "plain first-bit cycle", cyc, on0);
            if (v0) begin
                if (q0.size() == 0) chk(1'b0, "R5", "plain bit beyond product", 1, 0);
                else begin
                    bit e;
                    e = q0.pop_front();
                    chk(z0 == e, "R1 R2 R3", "plain product bit", int'(z0), int'(e));
                end
            end else begin
                chk(z0 == 1'b0, "R6", "plain output while invalid", int'(z0), 0);
            end
            pv0 = v0;
        end
    end

    // Monitor for the pipelined form.
    always @(negedge clk) begin
        if (rst_n) begin
            if (v1 && !pv1) chk(cyc == on1, "R4", "piped first-bit cycle", cyc, on1);
            if (v1) begin
                if (q1.size() == 0) chk(1'b0, "R5", "piped bit beyond product", 1, 0);
                else begin
                    bit e;
                    e = q1.pop_front();
                    chk(z1 == e, "R8", "piped product bit", int'(z1), int'(e));
                end
            end else begin
                chk(z1 == 1'b0, "R6", "piped output while invalid", int'(z1), 0);
            end
            pv1 = v1;
        end
    end

    // Driver: one run; abort_at > 0 means a new start follows after abort_at-1 bits.
    task automatic run_mul(input logic [M-1:0] xv, input logic [N-1:0] yv,
                           input int abort_at);
        logic [W-1:0] p;
        logic [M-1:0] mk;
        int nb0;
        int nb1;
        int nx;
        @(posedge clk); #1;
        start = 1'b1;
        y_in  = yv;
        x_in  = 1'b1;              // R2: ignored in the start cycle
        on0   = cyc + 2;
        on1   = cyc + N + 1;
        if (abort_at == 0) begin
            p   = W'(xv) * W'(yv);
            nb0 = W;
            nb1 = W;
            nx  = M;
        end else begin
            mk  = M'((1 << (abort_at - 1)) - 1);
            p   = W'(xv & mk) * W'(yv);
            nb0 = abort_at - 1;
            nb1 = abort_at - 1 - (N - 1);
            nx  = abort_at - 1;
        end
        for (int b = 0; b < nb0; b++) q0.push_back(p[b]);
        for (int b = 0; b < nb1; b++) q1.push_back(p[b]);
        for (int j = 0; j < nx; j++) begin
            @(posedge clk); #1;
            start = 1'b0;
            x_in  = xv[j];
            y_in  = ~yv;           // R3: scrambled after capture
            if (j == 0) begin
                @(negedge clk);
                chk(!v0 && !v1, "R7", "valid low after start", int'(v0 | v1), 0);
            end
        end
        if (abort_at == 0) begin
            @(posedge clk); #1;
            x_in = 1'b1;           // R2: flush cycles ignore x_in
            while (q0.size() != 0 || q1.size() != 0) @(posedge clk);
            repeat (4) @(posedge clk);
            chk(q0.size() == 0 && q1.size() == 0, "R5", "all product bits seen",
                q0.size() + q1.size(), 0);
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        x_in = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: idle after reset despite x_in held high
        chk(!v0 && !v1 && !z0 && !z1, "R9", "outputs after reset",
            int'({v0, z0, v1, z1}), 0);

        run_mul(8'hFF, 6'h3F, 0);   // largest operands
        run_mul(8'h00, 6'h2D, 0);   // zero serial operand
        run_mul(8'hB7, 6'h00, 0);   // zero parallel operand
        run_mul(8'h01, 6'h01, 0);
        run_mul(8'h80, 6'h20, 0);   // single top bits
        run_mul(8'hA5, 6'h2B, 0);
        run_mul(8'hFF, 6'h3F, 5);   // R7: aborted after four bits
        run_mul(8'h5A, 6'h11, 0);
        for (int i = 0; i < 6; i++)
            run_mul(8'(i * 37 + 11), 6'(i * 13 + 5), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule